// File: doc/BRIEF.md
# Serial Stereo Audio Receiver

This block takes a three-wire stereo audio stream and turns it into parallel sample pairs. The three wires are a bit clock, a word clock and a data line. All three are asynchronous to the system clock. The block synchronizes them and detects the bit-clock rising edges in the system clock domain. Each word-clock period carries a left word followed by a right word. Each word is 16 bits, two's complement, most significant bit first.

A word is right-justified: the word is the 16 bits captured on the last 16 bit clocks before a word-clock transition. Any earlier bits in that slot are dropped. When a right word completes after a left word, the pair is presented on the outputs and a one-cycle strobe is raised. The pair then holds until the next strobe.

The block also watches the data line for a long silent run. After 8192 consecutive bit clocks of zero data it raises a zero flag and forces both outputs to the mid-scale code. After reset is released, no pair is delivered until an initialization count of 1024 system clocks has elapsed.

Top module: `audio_serial_rx`

## Requirements
- R1: Words are sampled on bit-clock rising edges, MSB first. A completed left/right pair appears on `left_o`/`right_o` together with a `valid_o` pulse exactly one system clock wide.
- R2: A word is the last 16 bits captured before a word-clock transition. Bits sent earlier in the same slot have no effect on the delivered value.
- R3: Word clock high (1) marks the left slot and word clock low (0) marks the right slot. The left word is the one that completes on a 1→0 transition.
- R4: A right word that completes without a preceding left word since the last pair produces no `valid_o` pulse.
- R5: `zero_o` rises after 8192 consecutive bit clocks of zero data. It stays low after 8191.
- R6: A single bit sampled as one clears the zero run and drops `zero_o` at once. A new full run of 8192 zeros is then needed to raise it again.
- R7: While `zero_o` is high, `left_o` and `right_o` read 16'h0000. When it falls, the held pair is shown again.
- R8: After reset release, `ready_o` stays low for 1024 system clocks and rises on the 1024th. No `valid_o` pulse occurs while it is low, even when a full frame arrives during that time.
- R9: While `rst_ni` is low, `ready_o`, `zero_o` and `valid_o` are 0 and both sample outputs are 16'h0000.
- R10: `left_o`/`right_o` change only in a cycle where `valid_o` is high, unless `zero_o` is forcing them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bck_i | input | 1 | Serial bit clock |
| wck_i | input | 1 | Word clock, high for the left slot |
| dat_i | input | 1 | Serial data line |
| left_o | output | 16 | Left sample, two's complement |
| right_o | output | 16 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe marking a new pair |
| ready_o | output | 1 | High once initialization has finished |
| zero_o | output | 1 | Long zero run detected, outputs forced to mid-scale |

## Verification
The assertions assume that the bit clock holds each level for at least two system clocks. Under that assumption two detected rising edges can never fall in adjacent cycles, and the single-cycle strobe and the flag-clear checks rely on this. The assertions also assume that word clock and data change only while the bit clock is low, so that both are settled through the synchronizers when the edge is seen. The bench drives every bit-clock phase for two system clocks and updates word clock and data only at the start of the low phase, which keeps the stimulus inside these limits.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_ZERO_RUN = 8192;
  localparam int unsigned DEF_INIT_CYC = 1024;
endpackage

// File: rtl/rx_sync_bus.sv
module rx_sync_bus #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_frame_capture.sv
module rx_frame_capture
  import audio_rx_pkg::*;
#(
  parameter int unsigned W = DEF_SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_stb_i,
  input  logic         wck_i,
  input  logic         dat_i,
  input  logic         en_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         frame_o
);
  logic [W-1:0] sreg_q, lhold_q, left_q, right_q;
  chan_e        last_q, cur;
  logic         lseen_q, frame_q, slot_end;

  assign cur      = chan_e'(wck_i);
  assign slot_end = bit_stb_i && (cur != last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      lhold_q <= '0;
      left_q  <= '0;
      right_q <= '0;
      last_q  <= CH_RIGHT;
      lseen_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= 1'b0;
      if (bit_stb_i) begin
        sreg_q <= {sreg_q[W-2:0], dat_i};
        last_q <= cur;
      end
      // the word in sreg_q belongs to the slot that just ended
      if (slot_end) begin
        if (last_q == CH_LEFT) begin
          lhold_q <= sreg_q;
          lseen_q <= 1'b1;
        end else begin
          lseen_q <= 1'b0;
          if (lseen_q && en_i) begin
            left_q  <= lhold_q;
            right_q <= sreg_q;
            frame_q <= 1'b1;
          end
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign frame_o = frame_q;

  assert_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |=> !frame_q);
  assert_strobe_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |-> $past(en_i));
  assert_pair_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_q) || !$stable(right_q)) |-> frame_q);
endmodule

// File: rtl/rx_zero_watch.sv
module rx_zero_watch
  import audio_rx_pkg::*;
#(
  parameter int unsigned RUN = DEF_ZERO_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic dat_i,
  output logic zero_o
);
  localparam int unsigned CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (bit_stb_i) begin
      if (dat_i) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else if (cnt_q != CW'(RUN)) begin
        cnt_q  <= cnt_q + 1'b1;
        flag_q <= (cnt_q == CW'(RUN - 1));
      end
    end
  end

  assign zero_o = flag_q;

  assert_run_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(RUN));
  assert_flag_full_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> (cnt_q == CW'(RUN)));
  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && dat_i) |=> !flag_q);
endmodule

// File: rtl/rx_init_timer.sv
module rx_init_timer
  import audio_rx_pkg::*;
#(
  parameter int unsigned CYCLES = DEF_INIT_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(CYCLES - 1)) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  assert_ready_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q);
  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CYCLES));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = DEF_SAMPLE_W,
  parameter int unsigned ZERO_RUN    = DEF_ZERO_RUN,
  parameter int unsigned INIT_CYCLES = DEF_INIT_CYC,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bck_i,
  input  logic                wck_i,
  input  logic                dat_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                ready_o,
  output logic                zero_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0]     sync_q;
  logic                bck_s, wck_s, dat_s, bck_d, bit_stb;
  logic [SAMPLE_W-1:0] left_w, right_w;
  logic                ready_w, zero_w;

  rx_sync_bus #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dat_i, wck_i, bck_i}),
    .q_o   (sync_q)
  );

  assign {dat_s, wck_s, bck_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bck_d <= 1'b0;
    else         bck_d <= bck_s;
  end

  assign bit_stb = bck_s & ~bck_d;

  rx_init_timer #(.CYCLES(INIT_CYCLES)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(ready_w)
  );

  rx_frame_capture #(.W(SAMPLE_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_stb_i(bit_stb),
    .wck_i    (wck_s),
    .dat_i    (dat_s),
    .en_i     (ready_w),
    .left_o   (left_w),
    .right_o  (right_w),
    .frame_o  (valid_o)
  );

  rx_zero_watch #(.RUN(ZERO_RUN)) u_zero (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_stb_i(bit_stb),
    .dat_i    (dat_s),
    .zero_o   (zero_w)
  );

  // mid-scale in two's complement is all zeros
  assign left_o  = zero_w ? '0 : left_w;
  assign right_o = zero_w ? '0 : right_w;
  assign ready_o = ready_w;
  assign zero_o  = zero_w;

  assert_valid_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);
endmodule

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int ZRUN       = 8192;
  localparam int INIT       = 1024;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n, bck, wck, dat;
  logic [15:0] left_o, right_o;
  logic        valid_o, ready_o, zero_o;

  int          checks = 0;
  int          errors = 0;
  int          zrun = 0;
  int          nexp = 0;
  int          got = 0;
  logic [15:0] exp_l [64];
  logic [15:0] exp_r [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_rx u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .bck_i  (bck),
    .wck_i  (wck),
    .dat_i  (dat),
    .left_o (left_o),
    .right_o(right_o),
    .valid_o(valid_o),
    .ready_o(ready_o),
    .zero_o (zero_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0h exp %0h", req, what, act, exp);
    end
  endtask

  // pair monitor (R1, R2, R3, R4, R8)
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      chk("R8", "valid while not ready", int'(ready_o), 1);
      if (got < nexp) begin
        chk("R1", "left word", int'(left_o), int'(exp_l[got]));
        chk("R3", "right word", int'(right_o), int'(exp_r[got]));
      end else begin
        chk("R4", "unexpected pair index", got, nexp - 1);
      end
      got++;
    end
  end

  task automatic send_bit(input logic w, input logic d);
    bck = 1'b0; wck = w; dat = d;
    repeat (2) @(negedge clk);
    bck = 1'b1;
    repeat (2) @(negedge clk);
    if (d) zrun = 0;
    else if (zrun < ZRUN) zrun++;
  endtask

  task automatic settle();
    bck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic w, input logic [15:0] v, input int pad);
    for (int i = 0; i < pad; i++) send_bit(w, 1'($urandom_range(0, 1)));
    for (int i = 15; i >= 0; i--) send_bit(w, v[i]);
  endtask

  // R2: random padding ahead of each word
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input bit push);
    if (push) begin
      exp_l[nexp] = l;
      exp_r[nexp] = r;
      nexp++;
    end
    send_word(1'b1, l, $urandom_range(0, 8));
    send_word(1'b0, r, $urandom_range(0, 8));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bck = 1'b0; wck = 1'b0; dat = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "ready_o in reset", int'(ready_o), 0);
    chk("R9", "zero_o in reset", int'(zero_o), 0);
    chk("R9", "valid_o in reset", int'(valid_o), 0);
    chk("R9", "left_o in reset", int'(left_o), 0);
    chk("R9", "right_o in reset", int'(right_o), 0);
    rst_n = 1'b1;
    repeat (INIT - 1) @(negedge clk);
    chk("R8", "ready_o at 1023", int'(ready_o), 0);
    @(negedge clk);
    chk("R8", "ready_o at 1024", int'(ready_o), 1);

    // R4: orphan right word first
    send_word(1'b0, 16'hBEEF, 0);
    send_frame(16'h8000, 16'h7FFF, 1'b1);
    send_frame(16'hFFFF, 16'h0001, 1'b1);
    send_frame(16'h0000, 16'h0000, 1'b1);
    send_frame(16'h1234, 16'hEDCB, 1'b1);
    for (int k = 0; k < 20; k++)
      send_frame(16'($urandom), 16'($urandom), 1'b1);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R4", "pairs delivered", got, nexp);

    // R5/R6/R7 zero run while word clock is idle
    send_frame(16'hA5A5, 16'h3C3D, 1'b1);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R1", "pairs delivered before idle", got, nexp);
    while (zrun < ZRUN - 1) send_bit(1'b1, 1'b0);
    settle();
    chk("R5", "zero_o after 8191", int'(zero_o), 0);
    chk("R10", "left held while idle", int'(left_o), 16'hA5A5);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R5", "zero_o after 8192", int'(zero_o), 1);
    chk("R7", "left forced", int'(left_o), 0);
    chk("R7", "right forced", int'(right_o), 0);
    send_bit(1'b1, 1'b1);
    settle();
    chk("R6", "zero_o after one bit", int'(zero_o), 0);
    chk("R7", "left restored", int'(left_o), 16'hA5A5);
    chk("R7", "right restored", int'(right_o), 16'h3C3D);
    while (zrun < ZRUN - 1) send_bit(1'b1, 1'b0);
    settle();
    chk("R6", "zero_o after fresh 8191", int'(zero_o), 0);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R6", "zero_o after fresh 8192", int'(zero_o), 1);
    for (int k = 0; k < 6; k++)
      send_frame(16'($urandom) | 16'h0001, 16'($urandom), 1'b1);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R6", "zero_o after data", int'(zero_o), 0);
    chk("R1", "pairs after run", got, nexp);

    // mid-run reset
    rst_n = 1'b0; wck = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "ready_o mid reset", int'(ready_o), 0);
    chk("R9", "left_o mid reset", int'(left_o), 0);
    chk("R9", "right_o mid reset", int'(right_o), 0);
    rst_n = 1'b1;
    base = got;
    send_frame(16'h1111, 16'h2222, 1'b0);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R8", "ready_o during init", int'(ready_o), 0);
    chk("R8", "no pair during init", got, base);
    chk("R8", "left_o during init", int'(left_o), 0);
    wait (ready_o);
    @(negedge clk);
    for (int k = 0; k < 8; k++)
      send_frame(16'($urandom), 16'($urandom), 1'b1);
    send_bit(1'b1, 1'b0);
    settle();
    chk("R1", "pairs after reinit", got, nexp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule